// File: doc/BRIEF.md
# DDR SDRAM Command Sequence Monitor

This block watches the command pins of a four-bank double-data-rate SDRAM and reports any command that breaks the device's ordering rules. Each clock it turns the clock-enable, chip-select, row strobe, column strobe, write-enable, bank and address inputs into one command. It keeps a record of which banks hold an open row, and it runs a few timing windows that the rules depend on. These are the short quiet gap after a mode-register write, the data phase of a write that closes its own row, and the row-precharge wait that follows such a write.

The decoded command and the selected bank come out registered, one cycle after the pins are sampled. When a command breaks a rule, a sticky error flag rises together with a code that names the rule. Only the first error is kept until reset, so a later error does not hide the cause. Burst length and the precharge wait in cycles come from configuration inputs, which are sampled when a self-closing write is accepted. The block does not look at the data path or at strobe timing, and it does not schedule refresh.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: After reset, cmd_o reads 0 (idle), bank_o reads 0, err_flag_o is low and err_code_o is 0.
- R2: In a cycle where CKE was high on the previous edge and is high now, with cs_n low, the pin triple {ras_n,cas_n,we_n} decodes on cmd_o, one cycle later, as follows: 000 mode write = 3, 001 auto refresh = 4, 010 precharge = 10, 011 activate = 6, 100 write = 8, 101 read = 7, 110 burst stop = 9, 111 NOP = 2. Burst stop after an open write never raises an error.
- R3: bank_o shows {ba[1],ba[0]} as a bank number from 0 to 3. A precharge with addr[10] high closes all four banks whatever ba holds.
- R4: A mode write (regular or extended) while any bank is open sets error code 1.
- R5: In the cycle right after a mode write, any command other than NOP, deselect or idle sets error code 3. A command two cycles after the mode write is accepted.
- R6: An auto refresh, or a self-refresh entry (CKE high on the previous edge, low now, refresh pin pattern, which decodes as cmd_o = 5), while any bank is open sets error code 2.
- R7: A read or write to a bank that is not open sets error code 4. A read with addr[10] high closes its bank.
- R8: An activate to a bank that is already open sets error code 5.
- R9: After a write with addr[10] high is accepted at cycle t, a read or write to any bank in cycles t+1 to t+BL/2-1 sets error code 6. From t+BL/2 on, a read or write to another open bank is accepted.
- R10: After such a write, an activate to the same bank before cycle t+BL/2+tRP sets error code 7. An activate to that bank at exactly t+BL/2+tRP is accepted.
- R11: With cs_n high (and CKE high in both cycles), the cycle decodes as deselect (1) and is never an error. A cycle whose previous-edge CKE was low, or a CKE-dropping cycle that is not a self-refresh entry, decodes as idle (0) and is not checked. Bank state is unchanged across such cycles.
- R12: err_flag_o stays high once set until reset. err_code_o keeps the code of the first error, and err_code_o is non-zero exactly when err_flag_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable as seen on the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address bus; bit 10 is the auto/all-precharge flag |
| burst_len | input | 4 | Burst length: 2, 4 or 8 |
| trp_cycles | input | 4 | Row precharge wait in clock cycles, at least 1 |
| cmd_o | output | 4 | Registered decoded command code |
| bank_o | output | 2 | Registered selected bank |
| err_flag_o | output | 1 | Sticky error flag |
| err_code_o | output | 3 | Code of the first error seen |

## Verification
The hardest state to reach is the edge of the windows that follow a self-closing write. The bench has to place a read or an activate exactly one cycle inside and one cycle outside the burst lockout and the row-precharge wait, for more than one burst length. Each scenario starts from reset, opens the banks it needs, issues the self-closing write, and then pads with a counted number of NOPs. This puts the probe command on a cycle worked out from BL/2 and tRP. The same padding approach puts a command on the first cycle after a mode write, and again on the second cycle.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;
  typedef enum logic [3:0] {
    C_IDLE  = 4'd0,
    C_DESEL = 4'd1,
    C_NOP   = 4'd2,
    C_MRS   = 4'd3,
    C_REF   = 4'd4,
    C_SREF  = 4'd5,
    C_ACT   = 4'd6,
    C_RD    = 4'd7,
    C_WR    = 4'd8,
    C_BST   = 4'd9,
    C_PRE   = 4'd10
  } cmd_e;

  typedef enum logic [2:0] {
    E_NONE      = 3'd0,
    E_MRS_OPEN  = 3'd1,
    E_REF_OPEN  = 3'd2,
    E_MRD_GAP   = 3'd3,
    E_BANK_IDLE = 3'd4,
    E_BANK_BUSY = 3'd5,
    E_WAP_BURST = 3'd6,
    E_WAP_TRP   = 3'd7
  } err_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic              cke,
  input  logic              cke_q,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output cmd_e              cmd,
  output logic              ap
);
  logic unused_addr;
  assign unused_addr = ^addr;
  assign ap = addr[AP_BIT];

  always_comb begin
    cmd = C_IDLE;
    if (!cke_q) begin
      cmd = C_IDLE;
    end else if (!cke) begin
      cmd = (!cs_n && !ras_n && !cas_n && we_n) ? C_SREF : C_IDLE;
    end else if (cs_n) begin
      cmd = C_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = C_MRS;
        3'b001:  cmd = C_REF;
        3'b010:  cmd = C_PRE;
        3'b011:  cmd = C_ACT;
        3'b100:  cmd = C_WR;
        3'b101:  cmd = C_RD;
        3'b110:  cmd = C_BST;
        default: cmd = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cmd_e                 cmd,
  input  logic [BANK_W-1:0]    bank,
  input  logic                 ap,
  input  logic                 wap_close,
  input  logic [BANK_W-1:0]    wap_bank,
  output logic [NUM_BANKS-1:0] open
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (bank == BANK_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        open[g] <= 1'b0;
      end else if (cmd == C_ACT && hit) begin
        open[g] <= 1'b1;
      end else if (wap_close && wap_bank == BANK_W'(g)) begin
        open[g] <= 1'b0;
      end else if (cmd == C_PRE && (ap || hit)) begin
        open[g] <= 1'b0;
      end else if (cmd == C_RD && ap && hit) begin
        open[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ddr_cmd_windows.sv
module ddr_cmd_windows #(
  parameter int BL_W   = 4,
  parameter int TRP_W  = 4,
  parameter int MRD    = 2,
  parameter int BANK_W = 2,
  localparam int GAP_W = $clog2(MRD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mrs_fire,
  input  logic              wap_fire,
  input  logic [BANK_W-1:0] wap_bank_in,
  input  logic [BL_W-1:0]   half_in,
  input  logic [TRP_W-1:0]  trp_in,
  output logic              gap_busy,
  output logic              burst_busy,
  output logic              lock_busy,
  output logic [BANK_W-1:0] lock_bank,
  output logic              wap_close
);
  logic [GAP_W-1:0] gap_cnt;
  logic [BL_W-1:0]  wb_cnt;
  logic [TRP_W-1:0] trp_cnt;
  logic [TRP_W-1:0] trp_load;

  assign trp_load = (trp_in == '0) ? '0 : trp_in - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
    end else if (mrs_fire) begin
      gap_cnt <= GAP_W'(MRD - 1);
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_cnt    <= '0;
      trp_cnt   <= '0;
      lock_bank <= '0;
    end else if (wap_fire) begin
      wb_cnt    <= half_in;
      trp_cnt   <= '0;
      lock_bank <= wap_bank_in;
    end else begin
      if (wb_cnt != '0) wb_cnt <= wb_cnt - 1'b1;
      if (wb_cnt == BL_W'(1)) trp_cnt <= trp_load;
      else if (trp_cnt != '0) trp_cnt <= trp_cnt - 1'b1;
    end
  end

  assign gap_busy   = (gap_cnt != '0);
  assign burst_busy = (wb_cnt > BL_W'(1));
  assign wap_close  = (wb_cnt == BL_W'(1));
  assign lock_busy  = (wb_cnt != '0) || (trp_cnt != '0);
endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int NUM_BANKS = 4,
  parameter int BL_W      = 4,
  parameter int TRP_W     = 4,
  parameter int MRD       = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BL_W-1:0]   burst_len,
  input  logic [TRP_W-1:0]  trp_cycles,
  output logic [3:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              err_flag_o,
  output logic [2:0]        err_code_o
);
  logic cke_q;
  cmd_e cmd;
  logic ap;
  logic [NUM_BANKS-1:0] open;
  logic gap_busy, burst_busy, lock_busy, wap_close, wap_fire, mrs_fire, active;
  logic [BANK_W-1:0] lock_bank;
  err_e err_now;

  always_ff @(posedge clk) cke_q <= cke;

  ddr_cmd_decode #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) dec_i (
    .cke(cke), .cke_q(cke_q), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .cmd(cmd), .ap(ap)
  );

  ddr_bank_tracker #(.NUM_BANKS(NUM_BANKS)) trk_i (
    .clk(clk), .rst(rst), .cmd(cmd), .bank(ba), .ap(ap),
    .wap_close(wap_close), .wap_bank(lock_bank), .open(open)
  );

  ddr_cmd_windows #(.BL_W(BL_W), .TRP_W(TRP_W), .MRD(MRD), .BANK_W(BANK_W)) win_i (
    .clk(clk), .rst(rst), .mrs_fire(mrs_fire), .wap_fire(wap_fire),
    .wap_bank_in(ba), .half_in(burst_len >> 1), .trp_in(trp_cycles),
    .gap_busy(gap_busy), .burst_busy(burst_busy), .lock_busy(lock_busy),
    .lock_bank(lock_bank), .wap_close(wap_close)
  );

  assign active   = !(cmd inside {C_IDLE, C_DESEL, C_NOP});
  assign mrs_fire = (cmd == C_MRS);

  always_comb begin
    err_now = E_NONE;
    if (gap_busy && active) begin
      err_now = E_MRD_GAP;
    end else begin
      case (cmd)
        C_MRS:         if (|open) err_now = E_MRS_OPEN;
        C_REF, C_SREF: if (|open) err_now = E_REF_OPEN;
        C_RD, C_WR: begin
          if (burst_busy)    err_now = E_WAP_BURST;
          else if (!open[ba]) err_now = E_BANK_IDLE;
        end
        C_ACT: begin
          if (lock_busy && lock_bank == ba) err_now = E_WAP_TRP;
          else if (open[ba])                err_now = E_BANK_BUSY;
        end
        default: err_now = E_NONE;
      endcase
    end
  end

  assign wap_fire = (cmd == C_WR) && ap && (err_now == E_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o      <= 4'd0;
      bank_o     <= '0;
      err_flag_o <= 1'b0;
      err_code_o <= 3'd0;
    end else begin
      cmd_o  <= cmd;
      bank_o <= ba;
      if (!err_flag_o && err_now != E_NONE) begin
        err_flag_o <= 1'b1;
        err_code_o <= err_now;
      end
    end
  end
endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic       cs_n,
  input logic [3:0] cmd_o,
  input logic       err_flag_o,
  input logic [2:0] err_code_o
);
  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(err_flag_o) |-> err_flag_o);

  // R12
  err_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(err_flag_o) |-> $stable(err_code_o));

  // R11
  desel_decode_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cke) && cke && cs_n) |=> (cmd_o == 4'd1));

  // R5
  mrs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 4'd3) ##1 (cmd_o > 4'd2) |-> err_flag_o);

  // R12
  always @(negedge clk) begin
    if (!rst) begin
      flag_code_match_chk: assert (err_flag_o == (err_code_o != 3'd0));
    end
  end
endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk chk_i (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .cmd_o(cmd_o),
  .err_flag_o(err_flag_o), .err_code_o(err_code_o)
);

// File: tb/ddr_cmd_monitor_tb_top.sv
`timescale 1ns/1ps
module ddr_cmd_monitor_tb_top;
  localparam logic [3:0] K_IDLE = 4'd0, K_DESEL = 4'd1, K_NOP = 4'd2, K_MRS = 4'd3,
                         K_REF = 4'd4, K_SREF = 4'd5, K_ACT = 4'd6, K_RD = 4'd7,
                         K_WR = 4'd8, K_BST = 4'd9, K_PRE = 4'd10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic [12:0] addr = 13'd0;
  logic [3:0] burst_len = 4'd8;
  logic [3:0] trp_cycles = 4'd3;
  logic [3:0] cmd_o;
  logic [1:0] bank_o;
  logic err_flag_o;
  logic [2:0] err_code_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ddr_cmd_monitor dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .burst_len(burst_len), .trp_cycles(trp_cycles),
    .cmd_o(cmd_o), .bank_o(bank_o), .err_flag_o(err_flag_o), .err_code_o(err_code_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic k, input logic c, input logic r, input logic a,
                       input logic w, input logic [1:0] b, input logic ap);
    cke = k; cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = b;
    addr = 13'd0; addr[10] = ap;
    @(negedge clk);
  endtask

  task automatic issue(input logic [3:0] kind, input logic [1:0] b, input logic ap);
    case (kind)
      K_MRS:   drive(1, 0, 0, 0, 0, b, ap);
      K_REF:   drive(1, 0, 0, 0, 1, b, ap);
      K_PRE:   drive(1, 0, 0, 1, 0, b, ap);
      K_ACT:   drive(1, 0, 0, 1, 1, b, ap);
      K_WR:    drive(1, 0, 1, 0, 0, b, ap);
      K_RD:    drive(1, 0, 1, 0, 1, b, ap);
      K_BST:   drive(1, 0, 1, 1, 0, b, ap);
      K_DESEL: drive(1, 1, 1, 1, 1, b, ap);
      default: drive(1, 0, 1, 1, 1, b, ap);
    endcase
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(K_NOP, 2'd0, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    issue(K_NOP, 2'd0, 1'b0);
    issue(K_NOP, 2'd0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 cmd_o", cmd_o, 0);
    check("R1 bank_o", bank_o, 0);
    check("R1 err_flag_o", err_flag_o, 0);
    check("R1 err_code_o", err_code_o, 0);
  endtask

  task automatic t_decode();
    do_reset();
    issue(K_ACT, 2'd2, 0); check("R2 act code", cmd_o, K_ACT); check("R3 bank 2", bank_o, 2);
    issue(K_ACT, 2'd1, 0); check("R3 bank 1", bank_o, 1);
    issue(K_RD, 2'd2, 0);  check("R2 read code", cmd_o, K_RD);
    issue(K_WR, 2'd1, 0);  check("R2 write code", cmd_o, K_WR);
    issue(K_BST, 2'd0, 0); check("R2 burst stop code", cmd_o, K_BST);
    issue(K_PRE, 2'd3, 0); check("R2 precharge code", cmd_o, K_PRE); check("R3 bank 3", bank_o, 3);
    issue(K_NOP, 2'd0, 0); check("R2 nop code", cmd_o, K_NOP);
    issue(K_DESEL, 2'd0, 0); check("R11 deselect code", cmd_o, K_DESEL);
    check("R2 legal sequence no error", err_flag_o, 0);
  endtask

  task automatic t_pre_all();
    do_reset();
    issue(K_ACT, 2'd0, 0); issue(K_ACT, 2'd3, 0);
    issue(K_PRE, 2'd1, 1);
    issue(K_MRS, 2'd0, 0);
    check("R3 precharge all then mode write legal", err_code_o, 0);
    issue(K_NOP, 2'd0, 0);
    issue(K_REF, 2'd0, 0);
    check("R5 command two cycles after mode write legal", err_code_o, 0);
    check("R2 refresh code", cmd_o, K_REF);
  endtask

  task automatic t_mrs_open();
    do_reset();
    issue(K_ACT, 2'd1, 0); issue(K_MRS, 2'd0, 0);
    check("R4 mode write with open bank", err_code_o, 1);
    check("R4 flag", err_flag_o, 1);
  endtask

  task automatic t_mrs_gap();
    do_reset();
    issue(K_MRS, 2'd0, 0); issue(K_ACT, 2'd0, 0);
    check("R5 command right after mode write", err_code_o, 3);
  endtask

  task automatic t_refresh_open();
    do_reset();
    issue(K_ACT, 2'd0, 0); issue(K_REF, 2'd0, 0);
    check("R6 auto refresh with open bank", err_code_o, 2);
    do_reset();
    issue(K_ACT, 2'd2, 0);
    drive(0, 0, 0, 0, 1, 2'd0, 0);
    check("R6 self refresh decode", cmd_o, K_SREF);
    check("R6 self refresh with open bank", err_code_o, 2);
  endtask

  task automatic t_bank_idle();
    do_reset();
    issue(K_RD, 2'd2, 0);
    check("R7 read closed bank", err_code_o, 4);
    do_reset();
    issue(K_ACT, 2'd1, 0); issue(K_RD, 2'd1, 1); issue(K_WR, 2'd1, 0);
    check("R7 write after read with auto close", err_code_o, 4);
  endtask

  task automatic t_act_twice();
    do_reset();
    issue(K_ACT, 2'd1, 0); issue(K_ACT, 2'd1, 0);
    check("R8 activate open bank", err_code_o, 5);
    issue(K_RD, 2'd3, 0);
    check("R12 first code kept", err_code_o, 5);
    check("R12 flag held", err_flag_o, 1);
  endtask

  task automatic t_wap_burst();
    burst_len = 4'd8; trp_cycles = 4'd3;
    do_reset();
    issue(K_ACT, 2'd0, 0); issue(K_ACT, 2'd1, 0);
    issue(K_WR, 2'd0, 1); nops(1); issue(K_RD, 2'd1, 0);
    check("R9 read inside burst BL8", err_code_o, 6);
    do_reset();
    issue(K_ACT, 2'd0, 0); issue(K_ACT, 2'd1, 0);
    issue(K_WR, 2'd0, 1); nops(3); issue(K_RD, 2'd1, 0);
    check("R9 read at BL/2 BL8", err_code_o, 0);
    burst_len = 4'd2;
    do_reset();
    issue(K_ACT, 2'd0, 0); issue(K_ACT, 2'd1, 0);
    issue(K_WR, 2'd0, 1); issue(K_WR, 2'd1, 0); issue(K_BST, 2'd0, 0);
    check("R9 write next cycle BL2 and burst stop", err_code_o, 0);
  endtask

  task automatic t_wap_trp();
    burst_len = 4'd4; trp_cycles = 4'd3;
    do_reset();
    issue(K_ACT, 2'd0, 0); issue(K_WR, 2'd0, 1); nops(3); issue(K_ACT, 2'd0, 0);
    check("R10 activate one cycle early", err_code_o, 7);
    do_reset();
    issue(K_ACT, 2'd0, 0); issue(K_WR, 2'd0, 1); nops(4); issue(K_ACT, 2'd0, 0);
    check("R10 activate at BL/2+tRP", err_code_o, 0);
    burst_len = 4'd8; trp_cycles = 4'd2;
    do_reset();
    issue(K_ACT, 2'd3, 0); issue(K_WR, 2'd3, 1); nops(4); issue(K_ACT, 2'd3, 0);
    check("R10 BL8 activate early", err_code_o, 7);
  endtask

  task automatic t_cke_idle();
    burst_len = 4'd8; trp_cycles = 4'd3;
    do_reset();
    issue(K_ACT, 2'd0, 0);
    drive(0, 0, 0, 1, 1, 2'd0, 0);
    check("R11 cke drop decodes idle", cmd_o, K_IDLE);
    drive(0, 0, 0, 1, 1, 2'd0, 0);
    drive(1, 0, 0, 1, 1, 2'd0, 0);
    check("R11 cke low cycles unchecked", err_flag_o, 0);
    issue(K_DESEL, 2'd0, 0);
    check("R11 deselect legal", err_flag_o, 0);
    issue(K_ACT, 2'd0, 0);
    check("R11 bank state kept across idle", err_code_o, 5);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_decode();
    t_pre_all();
    t_mrs_open();
    t_mrs_gap();
    t_refresh_open();
    t_bank_idle();
    t_act_twice();
    t_wap_burst();
    t_wap_trp();
    t_cke_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule